// File: doc/BRIEF.md
# Three-Channel Prescaled Timer Counter

This peripheral holds three independent 16-bit up-counters behind one simple register bus with separate setup and access phases. All three channels run from the bus clock. Each channel has its own power-of-two prescaler, which is enabled by a control bit and set by a 4-bit exponent. A channel either free-runs and wraps, or runs in interval mode. In interval mode it returns to zero after reaching a programmed value and flags an interval event.

Software programs the prescaler, the interval value and the interrupt enable. It then writes the counter control with the restart bit set, so the new period is timed from zero. Every channel drives its own interrupt line. Software acknowledges an interrupt by reading that channel's status register.

Top module: `tmr_triple`

## Requirements
- R1: After reset every mapped register reads 0, every counter is 0 and all three interrupt outputs are low.
- R2: Channel k (0..2) sits at 4*k above each register group base. The group bases are: prescale control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and enable 0x60. Prescale control reads back bits [4:0] and counter control reads back bits [5:0] with bit 4 as 0. Interval reads back bits [15:0] and enable reads back bit 0. All other bits read 0. A misaligned or unmapped offset reads 0.
- R3: While counter-control bit 0 (halt) is 1, the count holds its value. The count advances on the clock edge of the write that sets halt, and freezes from the next edge on.
- R4: Prescale-control bit 0 enables the prescaler and bits [4:1] hold N. While the prescaler is enabled the counter advances once every 2^(N+1) clocks, counted from a restart. While it is disabled the counter advances on every clock.
- R5: With counter-control bit 1 at 0 (free-run), the count increments and wraps from 0xFFFF to 0. No status is raised.
- R6: A counter-control write with bit 4 set zeroes the count and the prescaler phase on the write's edge. The other written bits are stored as written. Bit 4 always reads 0. Bits 2, 3 and 5 are stored with no effect on counting.
- R7: With counter-control bit 1 at 1 (interval mode), an advance from a count equal to the interval value returns the count to 0 and sets status bit 0. The count therefore cycles through 0..interval.
- R8: A bus read of a channel's status register returns the status and then clears it. An interval event on the same edge as that read leaves the status set.
- R9: Interrupt output k is high exactly when status bit 0 and enable bit 0 of channel k are both 1.
- R10: Writes to the count and status registers are ignored. Each channel's counting is unaffected by bus traffic to the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select (setup and access phases) |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high in a read |
| irq | output | 3 | Per-channel interrupt, bit k for channel k |

## Verification
The hardest case is an interval event on exactly the clock edge on which a status read completes, because the ports give no direct control over when the event falls. The bench restarts a channel with the prescaler bypassed, so the event edge is known from the restart edge. It then counts clocks and starts the status read so that its access phase lands on that edge. A second read shows the status survived, and the interrupt line is checked before and after. Randomized runs cover arbitrary prescaler, interval and wait combinations, and a long directed run reaches the 0xFFFF wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register groups are 12 bytes apart, so the map has room for 3 channels.
  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned PRE_N_W = 4;
  localparam int unsigned PRE_W   = 2 ** PRE_N_W;
  localparam int unsigned CLK_W   = PRE_N_W + 1;
  localparam int unsigned CTL_W   = 6;
  localparam int unsigned CTL_RST_BIT = 4;

  localparam logic [ADDR_W-1:0] OFS_CLK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_VAL = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IVL = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ISR = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_IER = 8'h60;
  localparam logic [ADDR_W-1:0] GRP_SPAN = ADDR_W'(4 * NUM_CH);

  typedef enum logic [2:0] {
    REG_NONE, REG_CLK, REG_CTL, REG_VAL, REG_IVL, REG_ISR, REG_IER
  } reg_kind_e;

  typedef struct packed {
    logic       hit;
    reg_kind_e  kind;
    logic [CH_W-1:0] ch;
  } reg_sel_t;

  typedef struct packed {
    logic [PRE_N_W-1:0] n;
    logic               pen;
  } clk_cfg_t;

  typedef struct packed {
    logic wave_off;
    logic rsv3;
    logic rsv2;
    logic imode;
    logic halt;
  } ctl_cfg_t;

  function automatic logic grp_hit(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base);
    return (a[1:0] == 2'b00) && (a >= base) && (a < base + GRP_SPAN);
  endfunction

  function automatic logic [CH_W-1:0] grp_ch(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = (a - base) >> 2;
    return d[CH_W-1:0];
  endfunction

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s = '{hit: 1'b0, kind: REG_NONE, ch: '0};
    if (grp_hit(a, OFS_CLK)) s = '{hit: 1'b1, kind: REG_CLK, ch: grp_ch(a, OFS_CLK)};
    if (grp_hit(a, OFS_CTL)) s = '{hit: 1'b1, kind: REG_CTL, ch: grp_ch(a, OFS_CTL)};
    if (grp_hit(a, OFS_VAL)) s = '{hit: 1'b1, kind: REG_VAL, ch: grp_ch(a, OFS_VAL)};
    if (grp_hit(a, OFS_IVL)) s = '{hit: 1'b1, kind: REG_IVL, ch: grp_ch(a, OFS_IVL)};
    if (grp_hit(a, OFS_ISR)) s = '{hit: 1'b1, kind: REG_ISR, ch: grp_ch(a, OFS_ISR)};
    if (grp_hit(a, OFS_IER)) s = '{hit: 1'b1, kind: REG_IER, ch: grp_ch(a, OFS_IER)};
    return s;
  endfunction

  // Terminal prescaler phase for exponent n: 2^(n+1)-1, i.e. n+1 low ones.
  function automatic logic [PRE_W-1:0] presc_limit(input logic [PRE_N_W-1:0] n);
    logic [PRE_W-1:0] lim;
    for (int b = 0; b < PRE_W; b++) lim[b] = (b <= int'(n));
    return lim;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clear,
  input  logic               bypass,
  input  logic [PRE_N_W-1:0] n,
  output logic               tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;
  logic             at_end;

  assign limit  = presc_limit(n);
  assign at_end = phase_q >= limit;
  assign tick   = run && !clear && (bypass || at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= (bypass || at_end) ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic             wr_ctl,
  input  logic             wr_ivl,
  input  logic             wr_ier,
  input  logic             rd_isr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CLK_W-1:0] clk_rd,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ivl_q,
  output logic             isr_q,
  output logic             ier_q,
  output logic             irq,
  output logic             tick,
  output logic             restart,
  output logic             ev
);

  clk_cfg_t clk_q;
  ctl_cfg_t ctl_q;
  logic     hit;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic wrap_now);
    return wrap_now ? '0 : c + 1'b1;
  endfunction

  assign restart = wr_ctl && wdata[CTL_RST_BIT];
  assign hit     = ctl_q.imode && (cnt_q == ivl_q);
  assign ev      = tick && hit;
  assign irq     = isr_q && ier_q;

  assign clk_rd = {clk_q.n, clk_q.pen};
  assign ctl_rd = {ctl_q.wave_off, 1'b0, ctl_q.rsv3, ctl_q.rsv2, ctl_q.imode, ctl_q.halt};

  tmr_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (!ctl_q.halt),
    .clear  (restart),
    .bypass (!clk_q.pen),
    .n      (clk_q.n),
    .tick   (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ctl_q <= '0;
      ivl_q <= '0;
      ier_q <= 1'b0;
    end else begin
      if (wr_clk) clk_q <= '{n: wdata[PRE_N_W:1], pen: wdata[0]};
      if (wr_ctl) ctl_q <= '{wave_off: wdata[5], rsv3: wdata[3], rsv2: wdata[2],
                             imode: wdata[1], halt: wdata[0]};
      if (wr_ivl) ivl_q <= wdata;
      if (wr_ier) ier_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= step_count(cnt_q, hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 1'b0;
    end else if (ev) begin
      isr_q <= 1'b1;
    end else if (rd_isr) begin
      isr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NUM_CH-1:0][CLK_W-1:0] clk_rd,
  input  logic [NUM_CH-1:0][CTL_W-1:0] ctl_rd,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_rd,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ivl_rd,
  input  logic [NUM_CH-1:0]            isr_rd,
  input  logic [NUM_CH-1:0]            ier_rd,
  output logic [NUM_CH-1:0]            wr_clk,
  output logic [NUM_CH-1:0]            wr_ctl,
  output logic [NUM_CH-1:0]            wr_ivl,
  output logic [NUM_CH-1:0]            wr_ier,
  output logic [NUM_CH-1:0]            rd_isr,
  output logic [DATA_W-1:0]            prdata
);

  reg_sel_t sel;
  logic     acc_wr;
  logic     acc_rd;

  assign sel    = decode_addr(paddr);
  assign acc_wr = psel && penable && pwrite && sel.hit;
  assign acc_rd = psel && penable && !pwrite && sel.hit;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_strb
    logic mine;
    assign mine      = (sel.ch == CH_W'(k));
    assign wr_clk[k] = acc_wr && mine && (sel.kind == REG_CLK);
    assign wr_ctl[k] = acc_wr && mine && (sel.kind == REG_CTL);
    assign wr_ivl[k] = acc_wr && mine && (sel.kind == REG_IVL);
    assign wr_ier[k] = acc_wr && mine && (sel.kind == REG_IER);
    assign rd_isr[k] = acc_rd && mine && (sel.kind == REG_ISR);
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && sel.hit) begin
      case (sel.kind)
        REG_CLK: prdata = DATA_W'(clk_rd[sel.ch]);
        REG_CTL: prdata = DATA_W'(ctl_rd[sel.ch]);
        REG_VAL: prdata = DATA_W'(cnt_rd[sel.ch]);
        REG_IVL: prdata = DATA_W'(ivl_rd[sel.ch]);
        REG_ISR: prdata = DATA_W'(isr_rd[sel.ch]);
        REG_IER: prdata = DATA_W'(ier_rd[sel.ch]);
        default: prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_triple.sv
module tmr_triple
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [NUM_CH-1:0] irq
);

  logic [NUM_CH-1:0][CLK_W-1:0] ch_clk_rd;
  logic [NUM_CH-1:0][CTL_W-1:0] ch_ctl_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_ivl;
  logic [NUM_CH-1:0]            ch_isr;
  logic [NUM_CH-1:0]            ch_ier;
  logic [NUM_CH-1:0]            ch_wr_clk;
  logic [NUM_CH-1:0]            ch_wr_ctl;
  logic [NUM_CH-1:0]            ch_wr_ivl;
  logic [NUM_CH-1:0]            ch_wr_ier;
  logic [NUM_CH-1:0]            ch_rd_isr;
  // Internal events brought out for the bound checker.
  logic [NUM_CH-1:0]            ch_tick;
  logic [NUM_CH-1:0]            ch_restart;
  logic [NUM_CH-1:0]            ch_ev;
  logic                         unused_wdata_hi;

  assign unused_wdata_hi = ^pwdata[DATA_W-1:CNT_W];

  tmr_regbus #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bus (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .clk_rd  (ch_clk_rd),
    .ctl_rd  (ch_ctl_rd),
    .cnt_rd  (ch_cnt),
    .ivl_rd  (ch_ivl),
    .isr_rd  (ch_isr),
    .ier_rd  (ch_ier),
    .wr_clk  (ch_wr_clk),
    .wr_ctl  (ch_wr_ctl),
    .wr_ivl  (ch_wr_ivl),
    .wr_ier  (ch_wr_ier),
    .rd_isr  (ch_rd_isr),
    .prdata  (prdata)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_clk  (ch_wr_clk[k]),
      .wr_ctl  (ch_wr_ctl[k]),
      .wr_ivl  (ch_wr_ivl[k]),
      .wr_ier  (ch_wr_ier[k]),
      .rd_isr  (ch_rd_isr[k]),
      .wdata   (pwdata[CNT_W-1:0]),
      .clk_rd  (ch_clk_rd[k]),
      .ctl_rd  (ch_ctl_rd[k]),
      .cnt_q   (ch_cnt[k]),
      .ivl_q   (ch_ivl[k]),
      .isr_q   (ch_isr[k]),
      .ier_q   (ch_ier[k]),
      .irq     (irq[k]),
      .tick    (ch_tick[k]),
      .restart (ch_restart[k]),
      .ev      (ch_ev[k])
    );
  end

endmodule

// File: rtl/tmr_triple_chk.sv
module tmr_triple_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            restart,
  input logic [NUM_CH-1:0]            ev,
  input logic [NUM_CH-1:0]            rd_isr,
  input logic [NUM_CH-1:0]            isr,
  input logic [NUM_CH-1:0]            ier,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart[k] |=> cnt[k] == '0);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[k] && !restart[k]) |=> $stable(cnt[k]));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[k] && !restart[k] && !ev[k]) |=> cnt[k] == $past(cnt[k]) + 1'b1);

    // R7
    interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[k] |=> (cnt[k] == '0) && isr[k]);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_isr[k] && !ev[k]) |=> !isr[k]);

    // R8
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr[k] && !rd_isr[k]) |=> isr[k]);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> (isr[k] && ier[k]));
  end

endmodule

bind tmr_triple tmr_triple_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .tick    (ch_tick),
  .restart (ch_restart),
  .ev      (ch_ev),
  .rd_isr  (ch_rd_isr),
  .isr     (ch_isr),
  .ier     (ch_ier),
  .cnt     (ch_cnt)
);

// File: tb/tmr_triple_test.sv
module tmr_triple_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 4;
  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_VAL = 8'h18;
  localparam logic [7:0] A_IVL = 8'h24, A_ISR = 8'h54, A_IER = 8'h60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [2:0]  irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_c = 0;
  bit done = 1'b0;

  tmr_triple uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ra(input logic [7:0] grp, input int ch);
    return grp + 8'(4 * ch);
  endfunction

  function automatic int divisor(input bit pen, input int n);
    return pen ? (1 << (n + 1)) : 1;
  endfunction

  function automatic int exp_cnt(input int j, input int d, input bit im, input int iv);
    int t;
    t = j / d;
    return im ? (t % (iv + 1)) : (t % 65536);
  endfunction

  function automatic int exp_events(input int j, input int d, input int iv);
    return (j / d) / (iv + 1);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    last_c = cyc;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output int s,
                        output logic [2:0] irqs);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1; d = prdata; s = cyc; irqs = irq;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_until(input int c, input int m);
    while (cyc - c < m) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [2:0]  iq;
    int s, s2, c, c2;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values on every mapped register and on the interrupt lines
    check("R1 irq", irq, 0);
    for (int ch = 0; ch < 3; ch++) begin
      bus_rd(ra(A_CLK, ch), v, s, iq); check("R1 clk", v, 0);
      bus_rd(ra(A_CTL, ch), v, s, iq); check("R1 ctl", v, 0);
      bus_rd(ra(A_IVL, ch), v, s, iq); check("R1 ivl", v, 0);
      bus_rd(ra(A_ISR, ch), v, s, iq); check("R1 isr", v, 0);
      bus_rd(ra(A_IER, ch), v, s, iq); check("R1 ier", v, 0);
    end

    // R2: field widths on readback, unmapped and misaligned offsets
    bus_wr(ra(A_CLK, 1), 32'hFFFF_FFFF);
    bus_rd(ra(A_CLK, 1), v, s, iq); check("R2 clk readback", v, 32'h1F);
    bus_wr(ra(A_CTL, 1), 32'hFFFF_FFFF);
    bus_rd(ra(A_CTL, 1), v, s, iq); check("R2 ctl readback bit4 zero", v, 32'h2F);
    bus_wr(ra(A_IVL, 1), 32'h1234_ABCD);
    bus_rd(ra(A_IVL, 1), v, s, iq); check("R2 ivl readback", v, 32'hABCD);
    bus_wr(ra(A_IER, 1), 32'h0000_00FF);
    bus_rd(ra(A_IER, 1), v, s, iq); check("R2 ier readback", v, 1);
    bus_rd(8'h30, v, s, iq); check("R2 unmapped 0x30", v, 0);
    bus_rd(8'h0D, v, s, iq); check("R2 misaligned 0x0D", v, 0);
    bus_rd(8'h6C, v, s, iq); check("R2 unmapped 0x6C", v, 0);
    bus_rd(8'hFC, v, s, iq); check("R2 unmapped 0xFC", v, 0);

    // R8/R9: interval event on the same edge as a status read (ch1, interval 20, no prescale)
    bus_wr(ra(A_CLK, 1), 32'h0);
    bus_wr(ra(A_IER, 1), 32'h1);
    bus_wr(ra(A_IVL, 1), 32'd20);
    bus_wr(ra(A_CTL, 1), 32'h12);
    c = last_c;
    bus_rd(ra(A_CTL, 1), v, s, iq); check("R6 ctl kept after restart", v, 32'h02);
    bus_rd(ra(A_ISR, 1), v, s, iq);
    wait_until(c, 18);
    bus_rd(ra(A_ISR, 1), v, s, iq);
    check("R8 status before event", v, 0);
    check("R9 irq before event", iq[1], 0);
    bus_rd(ra(A_ISR, 1), v, s, iq);
    check("R8 event wins over clear", v, 1);
    check("R9 irq high with status and enable", iq[1], 1);
    check("R8 irq low after acknowledge", irq[1], 0);
    bus_rd(ra(A_VAL, 1), v, s, iq);
    check("R7 interval count", v, exp_cnt(s - c, 1, 1'b1, 20));

    // Random trials over channel, prescaler, mode, interval, enable and wait
    for (int t = 0; t < 30; t++) begin
      int ch, n, iv, wt, d, ev_n;
      bit pen, im, ie;
      logic [31:0] rsv;
      ch = $urandom_range(2, 0);
      pen = 1'($urandom_range(1, 0));
      n = $urandom_range(3, 0);
      im = 1'($urandom_range(1, 0));
      iv = $urandom_range(40, 3);
      ie = 1'($urandom_range(1, 0));
      rsv = $urandom & 32'h2C;
      d = divisor(pen, n);
      bus_wr(ra(A_CLK, ch), 32'((n << 1) | int'(pen)));
      bus_wr(ra(A_IER, ch), 32'(ie));
      bus_wr(ra(A_IVL, ch), 32'(iv));
      bus_wr(ra(A_CTL, ch), 32'h10 | (32'(im) << 1) | rsv);
      c = last_c;
      bus_rd(ra(A_ISR, ch), v, s, iq);
      wt = $urandom_range(150, 0);
      repeat (wt) @(negedge clk);
      bus_rd(ra(A_VAL, ch), v, s, iq);
      check(im ? "R7 random interval count" : "R4 R5 random free-run count",
            v, exp_cnt(s - c, d, im, iv));
      bus_rd(ra(A_ISR, ch), v, s, iq);
      ev_n = im ? exp_events(s - c, d, iv) : 0;
      check("R7 random status", v, (ev_n > 0) ? 1 : 0);
      check("R9 random irq", iq[ch], ((ev_n > 0) && ie) ? 1 : 0);
    end

    // R3: halt freezes the count one edge after the halting write
    bus_wr(ra(A_CLK, 0), 32'h0);
    bus_wr(ra(A_CTL, 0), 32'h10);
    c = last_c;
    bus_wr(ra(A_CTL, 0), 32'h01);
    c2 = last_c;
    bus_rd(ra(A_VAL, 0), v, s, iq); check("R3 frozen value", v, c2 - c);
    repeat (50) @(negedge clk);
    bus_rd(ra(A_VAL, 0), v2, s, iq); check("R3 still frozen", v2, v);

    // R10: writes to read-only count and status are ignored
    bus_wr(ra(A_VAL, 0), 32'hBEEF);
    bus_rd(ra(A_VAL, 0), v2, s, iq); check("R10 count write ignored", v2, v);
    bus_rd(ra(A_ISR, 0), v, s, iq);
    bus_wr(ra(A_ISR, 0), 32'h1);
    bus_rd(ra(A_ISR, 0), v, s, iq); check("R10 status write ignored", v, 0);

    // R4: exponent 10 divides by 2048, checked on both sides of the third advance
    bus_wr(ra(A_CLK, 0), 32'h15);
    bus_wr(ra(A_CTL, 0), 32'h10);
    c = last_c;
    wait_until(c, 2048 * 3 - 3);
    bus_rd(ra(A_VAL, 0), v, s, iq); check("R4 before third advance", v, exp_cnt(s - c, 2048, 1'b0, 0));
    check("R4 value 2 expected", exp_cnt(s - c, 2048, 1'b0, 0), 2);
    bus_rd(ra(A_VAL, 0), v, s, iq); check("R4 after third advance", v, 3);

    // R5: free-running wrap from 0xFFFF to 0 (ch2, no prescale)
    bus_wr(ra(A_CLK, 2), 32'h0);
    bus_wr(ra(A_CTL, 2), 32'h10);
    c = last_c;
    wait_until(c, 65533);
    bus_rd(ra(A_VAL, 2), v, s, iq); check("R5 top value", v, 32'hFFFF);
    bus_rd(ra(A_VAL, 2), v, s, iq); check("R5 wrapped value", v, exp_cnt(s - c, 1, 1'b0, 0));
    bus_rd(ra(A_ISR, 2), v, s, iq); check("R5 no status on wrap", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule